// File: doc/BRIEF.md
# PLCP Transmit Overhead Octet Generator

This block produces the four overhead octets that lead each row of a 57-octet-row PLCP transmit frame. For every row it emits two framing octets, a path overhead identifier (POI) octet that counts the rows of the frame down to zero with a parity bit, and one path overhead octet. The frame may be 12, 10 or 9 rows long, depending on the line type selected. Of the path overhead octets, only the B1 position carries data: a BIP-8 of the previous frame, into which a one-shot error pattern can be XORed. All growth and user-channel positions are sent as zero.

A framer pulses `row_start` once per row, after the previous row's octets have drained. It then pulls the four octets from a valid/ready source (`oh_valid`/`oh_ready`/`oh_data`). While `oh_valid` is high and `oh_ready` is low, the octet is held unchanged. The octets of the payload that go out between overhead columns are fed on a valid/ready sink (`pay_valid`/`pay_ready`/`pay_data`) so they enter the parity sum. This sink never stalls: `pay_ready` is tied high. Software loads an error pattern with `err_arm` and reads `err_busy` to learn when the insertion has been spent.

Top module: `plcp_oh_gen`

## Requirements
- R1: After reset `oh_valid` and `err_busy` are low, and the first accepted `row_start` opens a new frame whose B1 octet is 0x00.
- R2: Each accepted `row_start` yields exactly four octets in the order A1 = 0xF6, A2 = 0x28, POI, path overhead. `oh_valid` then falls.
- R3: `frame_type` (0 = 12 rows, 1 = 10 rows, 2 = 9 rows, 3 = 12 rows) is sampled only when a new frame opens. The POI index runs from rows−1 on the first row down to 0 on the last row, and a change of `frame_type` mid-frame has no effect until the next frame opens.
- R4: The POI octet has bit 7 = 0, the row index in bits [6:1], and bit 0 set so that bits [7:0] hold an odd number of ones.
- R5: The path overhead octet is 0x00 on every row except the row with index 4, which carries B1.
- R6: B1 equals the XOR of all payload octets accepted and all path overhead octets sent during the previous frame. Framing and POI octets are excluded.
- R7: With `oh_off` high at `row_start`, the A1, A2 and POI octets of that row are 0x00, while the path overhead octet and the BIP sum are unaffected.
- R8: An `err_arm` with a nonzero `err_pat` makes the B1 of the next frame to open equal the computed BIP XOR that pattern. Only that one frame is affected, and an arm with a zero pattern is ignored.
- R9: `err_busy` rises the cycle after an accepted arm. It stays high until the frame start that follows the frame into which the pattern was inserted.
- R10: While `oh_valid` is high and `oh_ready` is low, `oh_data` is held. A `row_start` during an unfinished row is ignored.
- R11: A payload octet accepted in the same cycle as a frame-opening `row_start` counts toward the new frame. An arm in that same cycle applies to the frame after the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_type | input | 2 | Row-count select, sampled at frame open |
| oh_off | input | 1 | Blank framing and POI octets for the row |
| row_start | input | 1 | Start-of-row strobe |
| pay_valid | input | 1 | Payload octet present |
| pay_ready | output | 1 | Payload sink ready (always high) |
| pay_data | input | 8 | Payload octet for the parity sum |
| err_arm | input | 1 | Load error pattern |
| err_pat | input | 8 | Error pattern for B1 |
| err_busy | output | 1 | Error insertion pending or in progress |
| oh_valid | output | 1 | Overhead octet present |
| oh_ready | input | 1 | Downstream takes the octet |
| oh_data | output | 8 | Overhead octet |

## Verification
Two events can fall into the same cycle: a frame-opening `row_start` and a payload octet, or that same strobe and an `err_arm`. The bench drives both pairs together on purpose, and it also drives them at random alongside random back-pressure. A reference model decides in which frame each payload octet and each arm belongs. Every B1 octet and every `err_busy` reading is compared with that model, so an octet counted in the wrong frame, or an arm spent one frame early, shows up as a wrong B1 or a wrong busy flag.

// File: rtl/plcp_oh_pkg.sv
package plcp_oh_pkg;
  localparam int OCT_W = 8;
  localparam int IDX_W = 6;
  localparam int B1_ROW = 4;

  typedef enum logic [1:0] {
    FT_ROWS12 = 2'd0,
    FT_ROWS10 = 2'd1,
    FT_ROWS9  = 2'd2,
    FT_RSVD   = 2'd3
  } ftype_e;

  typedef enum logic [1:0] {
    OC_A1  = 2'd0,
    OC_A2  = 2'd1,
    OC_POI = 2'd2,
    OC_POH = 2'd3
  } oct_e;

  localparam logic [OCT_W-1:0] FRAME_A1 = 8'hF6;
  localparam logic [OCT_W-1:0] FRAME_A2 = 8'h28;

  function automatic logic [IDX_W-1:0] top_index(input ftype_e t);
    case (t)
      FT_ROWS10: top_index = IDX_W'(9);
      FT_ROWS9:  top_index = IDX_W'(8);
      default:   top_index = IDX_W'(11);
    endcase
  endfunction

  function automatic logic [OCT_W-1:0] poi_octet(input logic [IDX_W-1:0] idx);
    poi_octet = {1'b0, idx, ~(^idx)};
  endfunction
endpackage

// File: rtl/plcp_row_seq.sv
module plcp_row_seq
  import plcp_oh_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          row_start,
  input  logic [1:0]    frame_type,
  input  logic          oh_off,
  input  logic          oh_ready,
  output logic          oh_valid,
  output oct_e          octet,
  output logic [IW-1:0] row_idx,
  output logic          row_off,
  output logic          frame_start,
  output logic          xfer
);
  logic accept;

  assign accept      = row_start && !oh_valid;
  assign frame_start = accept && (row_idx == '0);
  assign xfer        = oh_valid && oh_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oh_valid <= 1'b0;
      octet    <= OC_A1;
      row_idx  <= '0;
      row_off  <= 1'b0;
    end else if (accept) begin
      oh_valid <= 1'b1;
      octet    <= OC_A1;
      row_off  <= oh_off;
      if (row_idx == '0) row_idx <= IW'(top_index(ftype_e'(frame_type)));
      else               row_idx <= row_idx - 1'b1;
    end else if (xfer) begin
      if (octet == OC_POH) oh_valid <= 1'b0;
      else                 octet    <= oct_e'(octet + 2'd1);
    end
  end

  // R3
  row_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_idx <= IW'(11));

  // R10
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oh_valid && !oh_ready) |=> (oh_valid && $stable(octet) && $stable(row_idx)));

  // R2
  octet_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && octet != OC_POH) |=> (oh_valid && octet == oct_e'($past(octet) + 2'd1)));

  // R2
  row_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && octet == OC_POH) |=> !oh_valid);
endmodule

// File: rtl/plcp_bip_acc.sv
module plcp_bip_acc
  import plcp_oh_pkg::*;
#(
  parameter int W = OCT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic         pay_take,
  input  logic [W-1:0] pay_byte,
  input  logic         poh_take,
  input  logic [W-1:0] poh_byte,
  output logic [W-1:0] bip_prev
);
  logic [W-1:0] acc;
  logic [W-1:0] incoming;

  assign incoming = (pay_take ? pay_byte : '0) ^ (poh_take ? poh_byte : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      bip_prev <= '0;
    end else if (frame_start) begin
      bip_prev <= acc;
      acc      <= incoming;
    end else begin
      acc <= acc ^ incoming;
    end
  end

  // R6
  bip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(bip_prev));
endmodule

// File: rtl/plcp_err_ins.sv
module plcp_err_ins
  import plcp_oh_pkg::*;
#(
  parameter int W = OCT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic         arm,
  input  logic [W-1:0] pat,
  output logic [W-1:0] cur_pat,
  output logic         busy
);
  logic         pend_v;
  logic [W-1:0] pend_pat;
  logic         arm_ok;

  assign arm_ok = arm && (pat != '0);
  assign busy   = pend_v || (cur_pat != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_pat <= '0;
      cur_pat  <= '0;
    end else begin
      if (frame_start) begin
        cur_pat <= pend_v ? pend_pat : '0;
        pend_v  <= 1'b0;
      end
      if (arm_ok) begin
        pend_v   <= 1'b1;
        pend_pat <= pat;
      end
    end
  end

  // R9
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(arm));

  // R8
  pattern_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(cur_pat));
endmodule

// File: rtl/plcp_oh_gen.sv
module plcp_oh_gen
  import plcp_oh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       frame_type,
  input  logic             oh_off,
  input  logic             row_start,
  input  logic             pay_valid,
  output logic             pay_ready,
  input  logic [OCT_W-1:0] pay_data,
  input  logic             err_arm,
  input  logic [OCT_W-1:0] err_pat,
  output logic             err_busy,
  output logic             oh_valid,
  input  logic             oh_ready,
  output logic [OCT_W-1:0] oh_data
);
  oct_e             octet;
  logic [IDX_W-1:0] row_idx;
  logic             row_off;
  logic             frame_start;
  logic             xfer;
  logic [OCT_W-1:0] bip_prev;
  logic [OCT_W-1:0] cur_pat;
  logic [OCT_W-1:0] poh_val;
  logic             poh_take;

  assign pay_ready = 1'b1;

  plcp_row_seq #(.IW(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .row_start(row_start), .frame_type(frame_type),
    .oh_off(oh_off), .oh_ready(oh_ready), .oh_valid(oh_valid), .octet(octet),
    .row_idx(row_idx), .row_off(row_off), .frame_start(frame_start), .xfer(xfer)
  );

  plcp_err_ins #(.W(OCT_W)) u_err (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .arm(err_arm),
    .pat(err_pat), .cur_pat(cur_pat), .busy(err_busy)
  );

  assign poh_val  = (row_idx == IDX_W'(B1_ROW)) ? (bip_prev ^ cur_pat) : '0;
  assign poh_take = xfer && (octet == OC_POH);

  plcp_bip_acc #(.W(OCT_W)) u_bip (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .pay_take(pay_valid && pay_ready), .pay_byte(pay_data),
    .poh_take(poh_take), .poh_byte(poh_val), .bip_prev(bip_prev)
  );

  always_comb begin
    case (octet)
      OC_A1:   oh_data = row_off ? '0 : FRAME_A1;
      OC_A2:   oh_data = row_off ? '0 : FRAME_A2;
      OC_POI:  oh_data = row_off ? '0 : poi_octet(row_idx);
      default: oh_data = poh_val;
    endcase
  end

  // R7
  blank_overhead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oh_valid && row_off && octet != OC_POH) |-> (oh_data == '0));

  // R5
  zero_growth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oh_valid && octet == OC_POH && row_idx != IDX_W'(B1_ROW)) |-> (oh_data == '0));

  // R4
  poi_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oh_valid && octet == OC_POI && !row_off) |-> ((^oh_data) && !oh_data[7]));
endmodule

// File: tb/plcp_oh_gen_bench.sv
module plcp_oh_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] frame_type = 2'd0;
  logic       oh_off = 1'b0;
  logic       row_start = 1'b0;
  logic       pay_valid = 1'b0;
  logic       pay_ready;
  logic [7:0] pay_data = 8'h00;
  logic       err_arm = 1'b0;
  logic [7:0] err_pat = 8'h00;
  logic       err_busy;
  logic       oh_valid;
  logic       oh_ready = 1'b0;
  logic [7:0] oh_data;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // model state
  int       m_idx = 0;
  logic [7:0] m_acc = 0, m_hold = 0, m_cur = 0, m_pend_pat = 0;
  logic     m_pend_v = 0, m_off = 0;

  always #10 clk = ~clk;

  plcp_oh_gen u_plcp_oh_gen (
    .clk(clk), .rst_n(rst_n), .frame_type(frame_type), .oh_off(oh_off),
    .row_start(row_start), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .pay_data(pay_data), .err_arm(err_arm), .err_pat(err_pat),
    .err_busy(err_busy), .oh_valid(oh_valid), .oh_ready(oh_ready), .oh_data(oh_data)
  );

  function automatic int exp_top(input logic [1:0] t);
    if (t == 2'd1) return 9;
    if (t == 2'd2) return 8;
    return 11;
  endfunction

  function automatic logic [7:0] exp_poi(input int idx);
    logic [5:0] v;
    v = idx[5:0];
    return {1'b0, v, ~(^v)};
  endfunction

  function automatic logic [7:0] exp_oct(input int k);
    case (k)
      0: return m_off ? 8'h00 : 8'hF6;
      1: return m_off ? 8'h00 : 8'h28;
      2: return m_off ? 8'h00 : exp_poi(m_idx);
      default: return (m_idx == 4) ? (m_hold ^ m_cur) : 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      report();
    end
  end

  // one row: strobe with optional same-cycle payload / arm, then drain
  task automatic run_row(input logic [1:0] t, input logic off,
                         input logic pv, input logic [7:0] pb,
                         input logic arm, input logic [7:0] pat,
                         input logic extra_rs, input bit rnd_ready);
    int k;
    bit first;
    @(negedge clk);
    frame_type = t; oh_off = off; row_start = 1'b1;
    pay_valid = pv; pay_data = pb; err_arm = arm; err_pat = pat;
    if (m_idx == 0) begin
      m_hold = m_acc; m_acc = 8'h00;
      m_cur = m_pend_v ? m_pend_pat : 8'h00;
      m_pend_v = 1'b0;
      m_idx = exp_top(t);
    end else begin
      m_idx = m_idx - 1;
    end
    m_off = off;
    if (pv) m_acc ^= pb;
    if (arm && pat != 8'h00) begin m_pend_v = 1'b1; m_pend_pat = pat; end
    @(negedge clk);
    row_start = 1'b0; err_arm = 1'b0; pay_valid = 1'b0;
    frame_type = $urandom_range(0, 3);
    k = 0;
    first = 1'b1;
    while (k < 4) begin
      row_start = extra_rs && first;
      first = 1'b0;
      oh_ready = rnd_ready ? ($urandom_range(0, 2) != 0) : 1'b1;
      pay_valid = $urandom_range(0, 1);
      pay_data = $urandom;
      if (pay_valid) m_acc ^= pay_data;
      if (oh_ready) begin
        if (!oh_valid) check("R2 valid", {7'd0, oh_valid}, 8'h01);
        else begin
          case (k)
            0, 1: check(m_off ? "R7 framing" : "R2 framing", oh_data, exp_oct(k));
            2: check(m_off ? "R7 poi" : "R3 R4 poi", oh_data, exp_oct(k));
            default: check(m_idx == 4 ? "R6 R8 B1" : "R5 growth", oh_data, exp_oct(k));
          endcase
          if (k == 3) m_acc ^= exp_oct(3);
          k++;
        end
      end
      @(negedge clk);
    end
    row_start = 1'b0; oh_ready = 1'b0; pay_valid = 1'b0;
    check("R2 end", {7'd0, oh_valid}, 8'h00);
    check("R9 busy", {7'd0, err_busy}, {7'd0, (m_pend_v || m_cur != 8'h00)});
  endtask

  task automatic run_frame(input logic [1:0] t, input logic off, input bit rnd);
    do run_row(t, off, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, rnd); while (m_idx != 0);
  endtask

  initial begin
    void'($urandom(32'h5A17C3));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", {7'd0, oh_valid}, 8'h00);
    check("R1 busy", {7'd0, err_busy}, 8'h00);
    check("R1 pay_ready", {7'd0, pay_ready}, 8'h01);
    rst_n = 1'b1;
    // first frame: B1 must be zero (R1), plain DS3 rows
    run_frame(2'd0, 1'b0, 1'b0);
    // R3: 10-row and 9-row frames, type toggled mid-frame by run_row
    run_frame(2'd1, 1'b0, 1'b1);
    run_frame(2'd2, 1'b0, 1'b1);
    run_frame(2'd3, 1'b0, 1'b0);
    // R7: blanked framing and POI
    run_frame(2'd2, 1'b1, 1'b1);
    // R8: zero pattern ignored
    @(negedge clk); err_arm = 1'b1; err_pat = 8'h00;
    @(negedge clk); err_arm = 1'b0;
    check("R8 zero arm busy", {7'd0, err_busy}, 8'h00);
    run_frame(2'd1, 1'b0, 1'b0);
    // R8 R9: arm while idle, applies to next frame only
    @(negedge clk); err_arm = 1'b1; err_pat = 8'hA5;
    m_pend_v = 1'b1; m_pend_pat = 8'hA5;
    @(negedge clk); err_arm = 1'b0;
    check("R9 busy after arm", {7'd0, err_busy}, 8'h01);
    run_frame(2'd2, 1'b0, 1'b1);
    run_frame(2'd2, 1'b0, 1'b1);
    check("R9 busy cleared", {7'd0, err_busy}, 8'h00);
    // R11: payload and arm in the frame-opening cycle
    run_row(2'd1, 1'b0, 1'b1, 8'h3C, 1'b1, 8'h0F, 1'b0, 1'b1);
    while (m_idx != 0) run_row(2'd1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    run_row(2'd0, 1'b0, 1'b1, 8'hC3, 1'b0, 8'h00, 1'b0, 1'b1);
    while (m_idx != 0) run_row(2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1);
    run_frame(2'd2, 1'b0, 1'b0);
    // R10: row_start while a row is still draining is ignored
    for (int i = 0; i < 12; i++) run_row(2'd0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1);
    // random mix
    for (int i = 0; i < 300; i++) begin
      logic arm;
      arm = ($urandom_range(0, 9) == 0);
      run_row($urandom_range(0, 3), $urandom_range(0, 5) == 0, $urandom_range(0, 1),
              $urandom, arm, arm ? 8'($urandom) : 8'h00,
              $urandom_range(0, 4) == 0, 1'b1);
    end
    report();
  end
endmodule